// File: doc/BRIEF.md
# System Control Register Block

This block is a small bank of 32-bit control and identification registers on a simple register bus. The bus carries a byte offset, single-cycle read and write strobes, write data and registered read data. It exposes three identification words and a set of oscillator descriptor constants. It also provides two free-running tick counters that advance at 24 and 100 counts per microsecond, a 16-bit lock register, and a flags register that has its own clear offset.

The block also contains a configuration mailbox. Software puts a value in the mailbox data register and then writes the mailbox control word. When that word has its start bit set, the block sends one transfer over a side port to the sub-device that the low field of the word selects. The direction bit chooses a write, which sends the data register, or a read, which loads the data register with the reply. The side port answers in the same cycle as the request and reports whether a device is present at the selected target. When no device is present, the transfer is dropped without any error.

The register window is 0xD4 bytes. Any offset without a register reads as zero, and writes to it are discarded.

Top module: `sysctl_regblk`

## Requirements
- R1: After reset, the flags, lock and mailbox data registers read 0, `bus_rdata` is 0 and `sd_req` is low.
- R2: A read strobe in one cycle puts the addressed word on `bus_rdata` in the next cycle, and `bus_rdata` holds that value until the next read strobe. Offsets with no register read as 0, including every offset at or above 0xD4. Writes to those offsets change nothing.
- R3: Some offsets return fixed values:
  - 0x00, 0x04 and 0x08 return the identification parameters (defaults 0x41000001, 0x00000000 and 0x11000A01).
  - The five oscillator descriptors at 0x40 + 4*i return 0x00012C5C, 0x00002CC0, 0x00002C75, 0x00020211 and 0x00002C75, for i = 0 to 4.
  - The flash word at 0x30 reads 0, and the display word at 0x34 reads 0x00001F00.
  - Writes to all of these offsets, and to the reset-control offset 0x20, are ignored.
- R4: The mailbox status word at 0x2C always reads 1. The mailbox control word at 0x28 always reads 0.
- R5: A write to the flags register at 0x18 replaces its whole value. A write of any data to the flags-clear offset at 0x1C sets the flags register to 0.
- R6: A write to the lock register at 0x14 keeps only bits 15:0 of the write data. A read returns those 16 bits with bits 31:16 set to zero.
- R7: The counters at 0x0C and 0x10 advance by 24 and by 100 counts per microsecond. With the default 50 MHz clock, two reads taken exactly 100 cycles apart differ by 48 and by 200.
- R8: A write to the control word at 0x28 with bit 31 (start) clear sends no request and leaves the mailbox data register unchanged.
- R9: A write to the control word with bit 31 set raises `sd_req` for exactly one cycle, in the cycle after the write. In that cycle `sd_addr` carries bits 23:0 of the word and `sd_we` carries bit 30. Bits 29:24 have no effect.
- R10: In a write transfer (bit 30 = 1), `sd_wdata` carries the mailbox data register (offset 0x24) during the request, and the data register is left unchanged.
- R11: In a read transfer (bit 30 = 0) to a present device, the mailbox data register takes `sd_rdata` at the end of the request cycle and reads back with that value afterwards.
- R12: When `sd_present` is low during the request, a read transfer leaves the mailbox data register unchanged, and a write transfer is seen by no device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sd_req | output | 1 | One-cycle sub-device transfer request |
| sd_we | output | 1 | Transfer direction, 1 = write to the sub-device |
| sd_addr | output | 24 | Sub-device target field from the control word |
| sd_wdata | output | 32 | Data sent to the sub-device |
| sd_present | input | 1 | A device answers at `sd_addr` |
| sd_rdata | input | 32 | Sub-device reply data |

## Verification
The bench sweeps every word-aligned offset across the full 8-bit address space three times and compares each result with an arithmetic model:
- once after reset;
- once after writing all-ones and a checkerboard pattern to every offset that must ignore writes;
- once at the end of the run.

These sweeps separate decode errors and constant errors from writes that leak into registers they should not reach.

For the mailbox, the bench steps the target device number from 0 to 7 in both directions. Only targets 0 to 3 are present, so each step tells a dropped transfer from a serviced one and a read from a write. Separate cases set the reserved control bits and clear the start bit.

The counters are read in pairs exactly 50 and 100 cycles apart. This confirms that the 24-count rate accumulates its fraction correctly and that the 100-count rate advances by a whole step each cycle.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
   localparam int unsigned DW        = 32;
   localparam int unsigned WIN_BYTES = 'hD4;

   // register offsets (bytes, 4-byte aligned)
   localparam int unsigned OFF_ID0       = 'h00;
   localparam int unsigned OFF_ID1       = 'h04;
   localparam int unsigned OFF_BOARD     = 'h08;
   localparam int unsigned OFF_TICK24    = 'h0C;
   localparam int unsigned OFF_TICK100   = 'h10;
   localparam int unsigned OFF_LOCK      = 'h14;
   localparam int unsigned OFF_FLAGS     = 'h18;
   localparam int unsigned OFF_FLAGS_CLR = 'h1C;
   localparam int unsigned OFF_RESET     = 'h20;
   localparam int unsigned OFF_CFG_DATA  = 'h24;
   localparam int unsigned OFF_CFG_CTRL  = 'h28;
   localparam int unsigned OFF_CFG_STAT  = 'h2C;
   localparam int unsigned OFF_FLASH     = 'h30;
   localparam int unsigned OFF_DISPLAY   = 'h34;
   localparam int unsigned OSC_BASE      = 'h40;

   localparam logic [DW-1:0] DISPLAY_VAL = 32'h0000_1F00;
   localparam logic [DW-1:0] STAT_VAL    = 32'h0000_0001;

   // mailbox control word layout
   localparam int unsigned CW_START = 31;
   localparam int unsigned CW_DIR   = 30;
   localparam int unsigned TGT_W    = 24;

   typedef enum logic {
      SD_READ  = 1'b0,
      SD_WRITE = 1'b1
   } sd_dir_e;

   localparam int unsigned DEF_NUM_OSC = 5;
   localparam logic [DEF_NUM_OSC*DW-1:0] DEF_OSC_VALS = {
      32'h0000_2C75, 32'h0002_0211, 32'h0000_2C75,
      32'h0000_2CC0, 32'h0001_2C5C
   };
endpackage

// File: rtl/sysctl_tickgen.sv
`timescale 1ns/1ps
module sysctl_tickgen #(
   parameter int unsigned CLK_MHZ = 50,
   parameter int unsigned RATE    = 24,
   parameter int unsigned CNT_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned STEP = RATE / CLK_MHZ;
   localparam int unsigned REM  = RATE % CLK_MHZ;
   localparam logic [CNT_W-1:0] STEP_LO = CNT_W'(STEP);
   localparam logic [CNT_W-1:0] STEP_HI = CNT_W'(STEP + 1);

   generate
      if (CLK_MHZ == 0) begin : g_bad_clk
         $error("sysctl_tickgen: CLK_MHZ must be nonzero");
      end
      if (RATE == 0) begin : g_bad_rate
         $error("sysctl_tickgen: RATE must be nonzero");
      end

      if (REM == 0) begin : g_whole
         // rate is a whole multiple of the clock: fixed step
         always_ff @(posedge clk) begin
            if (!rst_n) count <= '0;
            else        count <= count + STEP_LO;
         end
      end else begin : g_frac
         // fractional rate: carry the remainder in a modulo accumulator
         localparam int unsigned ACC_W = $clog2(2 * CLK_MHZ);
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W-1:0] acc_sum;
         logic             carry;

         assign acc_sum = acc_q + ACC_W'(REM);
         assign carry   = acc_sum >= ACC_W'(CLK_MHZ);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q <= '0;
               count <= '0;
            end else begin
               acc_q <= carry ? acc_sum - ACC_W'(CLK_MHZ) : acc_sum;
               count <= count + (carry ? STEP_HI : STEP_LO);
            end
         end
      end
   endgenerate

   // R7: every cycle the count moves by the floor or ceiling of RATE/CLK_MHZ
   a_r7_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((count - $past(count)) == STEP_LO) || ((count - $past(count)) == STEP_HI));
endmodule

// File: rtl/sysctl_mailbox.sv
`timescale 1ns/1ps
module sysctl_mailbox
   import sysctl_pkg::*;
#(
   parameter int unsigned TW = TGT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          data_we,
   input  logic          ctrl_we,
   input  logic          cw_start,
   input  logic          cw_dir,
   input  logic [TW-1:0] cw_tgt,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] data_q,
   output logic          sd_req,
   output logic          sd_we,
   output logic [TW-1:0] sd_addr,
   output logic [DW-1:0] sd_wdata,
   input  logic          sd_present,
   input  logic [DW-1:0] sd_rdata
);
   generate
      if (TW > CW_DIR) begin : g_bad_tw
         $error("sysctl_mailbox: target field overlaps the direction bit");
      end
   endgenerate

   sd_dir_e dir_q;
   logic    launch;
   logic    load_reply;

   assign launch     = ctrl_we && cw_start;
   assign load_reply = sd_req && (dir_q == SD_READ) && sd_present;

   // request stage: one cycle per accepted control write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sd_req  <= 1'b0;
         dir_q   <= SD_READ;
         sd_addr <= '0;
      end else begin
         sd_req <= launch;
         if (launch) begin
            dir_q   <= sd_dir_e'(cw_dir);
            sd_addr <= cw_tgt;
         end
      end
   end

   // data register: a reply beats a bus write landing in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)          data_q <= '0;
      else if (load_reply) data_q <= sd_rdata;
      else if (data_we)    data_q <= wdata;
   end

   assign sd_we    = (dir_q == SD_WRITE);
   assign sd_wdata = data_q;

   // R9: a request only follows a control write with the start bit set
   a_r9_req_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
      sd_req |-> $past(ctrl_we && cw_start));

   // R8: a control write with the start bit clear raises no request
   a_r8_no_start_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !cw_start) |=> !sd_req);

   // R11: a serviced read loads the reply
   a_r11_reply_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_req && !sd_we && sd_present) |=> (data_q == $past(sd_rdata)));

   // R12: an absent device leaves the data register alone
   a_r12_absent_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_req && !sd_present && !data_we) |=> $stable(data_q));

   // R10: a write transfer does not disturb the data register
   a_r10_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_req && sd_we && !data_we) |=> $stable(data_q));
endmodule

// File: rtl/sysctl_csr.sv
`timescale 1ns/1ps
module sysctl_csr
   import sysctl_pkg::*;
#(
   parameter int unsigned          ADDR_W       = 8,
   parameter logic [DW-1:0]        ID0_VAL      = 32'h4100_0001,
   parameter logic [DW-1:0]        ID1_VAL      = 32'h0000_0000,
   parameter logic [DW-1:0]        BOARD_VAL    = 32'h1100_0A01,
   parameter int unsigned          NUM_OSC      = DEF_NUM_OSC,
   parameter logic [NUM_OSC*DW-1:0] OSC_VALS    = DEF_OSC_VALS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [DW-1:0]     tick24,
   input  logic [DW-1:0]     tick100,
   input  logic [DW-1:0]     cfg_data,
   output logic              data_we,
   output logic              ctrl_we
);
   localparam logic [ADDR_W-1:0] A_ID0       = ADDR_W'(OFF_ID0);
   localparam logic [ADDR_W-1:0] A_ID1       = ADDR_W'(OFF_ID1);
   localparam logic [ADDR_W-1:0] A_BOARD     = ADDR_W'(OFF_BOARD);
   localparam logic [ADDR_W-1:0] A_TICK24    = ADDR_W'(OFF_TICK24);
   localparam logic [ADDR_W-1:0] A_TICK100   = ADDR_W'(OFF_TICK100);
   localparam logic [ADDR_W-1:0] A_LOCK      = ADDR_W'(OFF_LOCK);
   localparam logic [ADDR_W-1:0] A_FLAGS     = ADDR_W'(OFF_FLAGS);
   localparam logic [ADDR_W-1:0] A_FLAGS_CLR = ADDR_W'(OFF_FLAGS_CLR);
   localparam logic [ADDR_W-1:0] A_CFG_DATA  = ADDR_W'(OFF_CFG_DATA);
   localparam logic [ADDR_W-1:0] A_CFG_CTRL  = ADDR_W'(OFF_CFG_CTRL);
   localparam logic [ADDR_W-1:0] A_CFG_STAT  = ADDR_W'(OFF_CFG_STAT);
   localparam logic [ADDR_W-1:0] A_DISPLAY   = ADDR_W'(OFF_DISPLAY);
   localparam logic [ADDR_W-1:0] A_WIN       = ADDR_W'(WIN_BYTES);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("sysctl_csr: ADDR_W too narrow for the register window");
      end
      if (OSC_BASE + 4 * NUM_OSC > WIN_BYTES) begin : g_bad_osc
         $error("sysctl_csr: oscillator descriptors run past the window");
      end
      if ((OSC_BASE % 4) != 0) begin : g_bad_align
         $error("sysctl_csr: oscillator base must be word aligned");
      end
   endgenerate

   logic [15:0]   lock_q;
   logic [DW-1:0] flags_q;
   logic [DW-1:0] rd_val;
   logic [DW-1:0] osc_word;
   logic [NUM_OSC-1:0] osc_hit;

   // write decode
   logic lock_we, flags_we, flags_clr_we;
   assign lock_we      = bus_wr && (bus_addr == A_LOCK);
   assign flags_we     = bus_wr && (bus_addr == A_FLAGS);
   assign flags_clr_we = bus_wr && (bus_addr == A_FLAGS_CLR);
   assign data_we      = bus_wr && (bus_addr == A_CFG_DATA);
   assign ctrl_we      = bus_wr && (bus_addr == A_CFG_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q  <= '0;
         flags_q <= '0;
      end else begin
         if (lock_we) lock_q <= bus_wdata[15:0];
         if (flags_clr_we)  flags_q <= '0;
         else if (flags_we) flags_q <= bus_wdata;
      end
   end

   // oscillator descriptor constants, one comparator per entry
   for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
      assign osc_hit[i] = (bus_addr == ADDR_W'(OSC_BASE + 4 * i));
   end

   always_comb begin
      osc_word = '0;
      for (int i = 0; i < NUM_OSC; i++) begin
         if (osc_hit[i]) osc_word = osc_word | OSC_VALS[i*DW +: DW];
      end
   end

   // read mux; flash, reset control, flags clear and undecoded read zero
   always_comb begin
      unique case (bus_addr)
         A_ID0:      rd_val = ID0_VAL;
         A_ID1:      rd_val = ID1_VAL;
         A_BOARD:    rd_val = BOARD_VAL;
         A_TICK24:   rd_val = tick24;
         A_TICK100:  rd_val = tick100;
         A_LOCK:     rd_val = {16'h0000, lock_q};
         A_FLAGS:    rd_val = flags_q;
         A_CFG_DATA: rd_val = cfg_data;
         A_CFG_CTRL: rd_val = '0;
         A_CFG_STAT: rd_val = STAT_VAL;
         A_DISPLAY:  rd_val = DISPLAY_VAL;
         default:    rd_val = osc_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end

   // R5: flags clear empties the register whatever the data
   a_r5_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flags_clr_we |=> (flags_q == '0));

   // R6: lock keeps only the low half of the write data
   a_r6_lock_low16: assert property (@(posedge clk) disable iff (!rst_n)
      lock_we |=> (lock_q == $past(bus_wdata[15:0])));

   // R4: status reads one, control reads zero
   a_r4_status_one: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_CFG_STAT) |=> (bus_rdata == 32'd1));
   a_r4_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_CFG_CTRL) |=> (bus_rdata == '0));

   // R2: read data holds between strobes; outside the window reads zero
   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   a_r2_out_of_window: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr >= A_WIN) |=> (bus_rdata == '0));
endmodule

// File: rtl/sysctl_regblk.sv
`timescale 1ns/1ps
module sysctl_regblk
   import sysctl_pkg::*;
#(
   parameter int unsigned           ADDR_W    = 8,
   parameter int unsigned           CLK_MHZ   = 50,
   parameter logic [DW-1:0]         ID0_VAL   = 32'h4100_0001,
   parameter logic [DW-1:0]         ID1_VAL   = 32'h0000_0000,
   parameter logic [DW-1:0]         BOARD_VAL = 32'h1100_0A01,
   parameter int unsigned           NUM_OSC   = DEF_NUM_OSC,
   parameter logic [NUM_OSC*DW-1:0] OSC_VALS  = DEF_OSC_VALS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sd_req,
   output logic              sd_we,
   output logic [23:0]       sd_addr,
   output logic [31:0]       sd_wdata,
   input  logic              sd_present,
   input  logic [31:0]       sd_rdata
);
   logic [DW-1:0] tick24, tick100, cfg_data;
   logic          data_we, ctrl_we;

   sysctl_tickgen #(.CLK_MHZ(CLK_MHZ), .RATE(24), .CNT_W(DW)) u_tick24 (
      .clk(clk), .rst_n(rst_n), .count(tick24)
   );

   sysctl_tickgen #(.CLK_MHZ(CLK_MHZ), .RATE(100), .CNT_W(DW)) u_tick100 (
      .clk(clk), .rst_n(rst_n), .count(tick100)
   );

   sysctl_csr #(
      .ADDR_W(ADDR_W), .ID0_VAL(ID0_VAL), .ID1_VAL(ID1_VAL),
      .BOARD_VAL(BOARD_VAL), .NUM_OSC(NUM_OSC), .OSC_VALS(OSC_VALS)
   ) u_csr (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick24(tick24), .tick100(tick100), .cfg_data(cfg_data),
      .data_we(data_we), .ctrl_we(ctrl_we)
   );

   sysctl_mailbox #(.TW(TGT_W)) u_mbx (
      .clk(clk), .rst_n(rst_n),
      .data_we(data_we), .ctrl_we(ctrl_we),
      .cw_start(bus_wdata[CW_START]), .cw_dir(bus_wdata[CW_DIR]),
      .cw_tgt(bus_wdata[TGT_W-1:0]), .wdata(bus_wdata),
      .data_q(cfg_data),
      .sd_req(sd_req), .sd_we(sd_we), .sd_addr(sd_addr),
      .sd_wdata(sd_wdata), .sd_present(sd_present), .sd_rdata(sd_rdata)
   );

   // R1: no transfer may be pending while reset is held
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> !sd_req);
endmodule

// File: tb/sysctl_regblk_tb.sv
`timescale 1ns/1ps
module sysctl_regblk_tb;
   import sysctl_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic        bus_rd, bus_wr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        sd_req, sd_we, sd_present;
   logic [23:0] sd_addr;
   logic [31:0] sd_wdata, sd_rdata;

   always #10 clk = ~clk;   // 50 MHz

   sysctl_regblk u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sd_req(sd_req), .sd_we(sd_we), .sd_addr(sd_addr), .sd_wdata(sd_wdata),
      .sd_present(sd_present), .sd_rdata(sd_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state
   logic [31:0] m_flags, m_data;
   logic [15:0] m_lock;

   // sub-device stub: present for function 1, devices 0..3
   function automatic bit stub_here(logic [23:0] t);
      return (t[23:18] == 6'd1) && (t[11:0] < 12'd4);
   endfunction
   function automatic logic [31:0] stub_val(logic [23:0] t);
      return 32'h5EED_0000 ^ {8'h00, t};
   endfunction
   assign sd_present = stub_here(sd_addr);
   assign sd_rdata   = stub_val(sd_addr);

   int          req_cnt = 0, wr_cnt = 0, dbl_cnt = 0;
   bit          prev_req = 0;
   logic [23:0] last_tgt = '0;
   logic        last_we = 0;
   logic [31:0] last_wdata = '0;
   always @(posedge clk) begin
      if (rst_n && sd_req) begin
         req_cnt++;
         last_tgt = sd_addr;
         last_we  = sd_we;
         if (sd_we && sd_present) begin
            wr_cnt++;
            last_wdata = sd_wdata;
         end
      end
      if (sd_req && prev_req) dbl_cnt++;
      prev_req = sd_req;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] expect_at(int unsigned a);
      if (a == OFF_ID0)      return 32'h4100_0001;
      if (a == OFF_ID1)      return 32'h0000_0000;
      if (a == OFF_BOARD)    return 32'h1100_0A01;
      if (a == OFF_LOCK)     return {16'h0, m_lock};
      if (a == OFF_FLAGS)    return m_flags;
      if (a == OFF_CFG_DATA) return m_data;
      if (a == OFF_CFG_STAT) return 32'd1;
      if (a == OFF_DISPLAY)  return 32'h0000_1F00;
      if (a == 'h40) return 32'h0001_2C5C;
      if (a == 'h44) return 32'h0000_2CC0;
      if (a == 'h48) return 32'h0000_2C75;
      if (a == 'h4C) return 32'h0002_0211;
      if (a == 'h50) return 32'h0000_2C75;
      return 32'h0;
   endfunction

   function automatic string tag_at(int unsigned a);
      if (a == OFF_CFG_STAT || a == OFF_CFG_CTRL) return "R4 status/control";
      if (a == OFF_FLAGS) return "R5 flags";
      if (a == OFF_LOCK)  return "R6 lock";
      if (a == OFF_CFG_DATA) return "R11 mailbox data";
      if (a <= OFF_BOARD || a == OFF_FLASH || a == OFF_DISPLAY ||
          (a >= 'h40 && a <= 'h50)) return "R3 constant";
      return "R2 undecoded";
   endfunction

   task automatic sweep_reads();
      logic [31:0] d;
      for (int a = 0; a < 256; a += 4) begin
         if (a == OFF_TICK24 || a == OFF_TICK100) continue;
         bus_read(8'(a), d);
         chk($sformatf("%s @0x%02h", tag_at(a), a), d, expect_at(a));
      end
   endtask

   task automatic mbx(bit start, bit dir, logic [5:0] rsvd, logic [23:0] tgt);
      int r0, w0;
      logic [31:0] d;
      r0 = req_cnt; w0 = wr_cnt;
      bus_write(OFF_CFG_CTRL[7:0], {start, dir, rsvd, tgt});
      @(negedge clk);
      if (!start) begin
         chk("R8 no request", 32'(req_cnt - r0), 32'd0);
      end else begin
         chk("R9 one request", 32'(req_cnt - r0), 32'd1);
         chk("R9 target", {8'h0, last_tgt}, {8'h0, tgt});
         chk("R9 direction", {31'h0, last_we}, {31'h0, dir});
         if (dir) begin
            chk("R10/R12 device write seen", 32'(wr_cnt - w0),
                stub_here(tgt) ? 32'd1 : 32'd0);
            if (stub_here(tgt)) chk("R10 write data", last_wdata, m_data);
         end else if (stub_here(tgt)) begin
            m_data = stub_val(tgt);
         end
      end
      bus_read(OFF_CFG_DATA[7:0], d);
      chk(dir || !start ? "R10 data kept" :
          (stub_here(tgt) ? "R11 reply loaded" : "R12 absent keeps data"), d, m_data);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, t0, t1;
      rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
      m_flags = '0; m_data = '0; m_lock = '0;
      repeat (3) @(negedge clk);
      chk("R1 rdata reset", bus_rdata, 32'h0);
      chk("R1 sd_req reset", {31'h0, sd_req}, 32'h0);
      rst_n = 1'b1;

      // R1/R2/R3/R4: full sweep of the fresh block
      sweep_reads();

      // R5: flags replace and clear
      bus_write(OFF_FLAGS[7:0], 32'hA5A5_0F0F); m_flags = 32'hA5A5_0F0F;
      bus_read(OFF_FLAGS[7:0], d); chk("R5 flags write", d, m_flags);
      bus_write(OFF_FLAGS[7:0], 32'h0000_0001); m_flags = 32'h1;
      bus_read(OFF_FLAGS[7:0], d); chk("R5 flags replace", d, m_flags);
      bus_write(OFF_FLAGS_CLR[7:0], 32'h0); m_flags = '0;
      bus_read(OFF_FLAGS[7:0], d); chk("R5 flags clear zero data", d, 32'h0);
      bus_write(OFF_FLAGS[7:0], 32'h8000_0000);
      bus_write(OFF_FLAGS_CLR[7:0], 32'hFFFF_FFFF);
      bus_read(OFF_FLAGS[7:0], d); chk("R5 flags clear ones data", d, 32'h0);

      // R6: lock low half
      bus_write(OFF_LOCK[7:0], 32'hDEAD_BEEF); m_lock = 16'hBEEF;
      bus_read(OFF_LOCK[7:0], d); chk("R6 lock low16", d, 32'h0000_BEEF);
      bus_write(OFF_FLAGS[7:0], 32'h1234_0000); m_flags = 32'h1234_0000;
      bus_write(OFF_CFG_DATA[7:0], 32'h0BAD_F00D); m_data = 32'h0BAD_F00D;

      // R2/R3: writes to read-only and undecoded offsets change nothing
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < 256; a += 4) begin
            if (a == OFF_FLAGS || a == OFF_FLAGS_CLR || a == OFF_LOCK ||
                a == OFF_CFG_DATA || a == OFF_CFG_CTRL) continue;
            bus_write(8'(a), p == 0 ? 32'hFFFF_FFFF : 32'h5A5A_5A5A);
         end
      end
      sweep_reads();

      // R7: tick rates
      bus_read(OFF_TICK24[7:0], t0); repeat (98) @(negedge clk);
      bus_read(OFF_TICK24[7:0], t1); chk("R7 tick24 over 100 cycles", t1 - t0, 32'd48);
      bus_read(OFF_TICK24[7:0], t0); repeat (48) @(negedge clk);
      bus_read(OFF_TICK24[7:0], t1); chk("R7 tick24 over 50 cycles", t1 - t0, 32'd24);
      bus_read(OFF_TICK100[7:0], t0); repeat (98) @(negedge clk);
      bus_read(OFF_TICK100[7:0], t1); chk("R7 tick100 over 100 cycles", t1 - t0, 32'd200);

      // R8..R12: mailbox
      bus_write(OFF_CFG_DATA[7:0], 32'h1234_5678); m_data = 32'h1234_5678;
      mbx(1'b0, 1'b1, 6'h00, {6'd1, 6'd0, 12'd2});
      mbx(1'b0, 1'b0, 6'h00, {6'd1, 6'd0, 12'd2});
      mbx(1'b1, 1'b1, 6'h3F, {6'd1, 6'd0, 12'd2});
      for (int dv = 0; dv < 8; dv++) begin
         mbx(1'b1, 1'b0, 6'h00, {6'd1, 6'd0, 12'(dv)});
         mbx(1'b1, 1'b1, 6'h15, {6'd1, 6'd0, 12'(dv)});
      end
      mbx(1'b1, 1'b0, 6'h2A, {6'd2, 6'd0, 12'd1});
      mbx(1'b1, 1'b1, 6'h00, {6'd2, 6'd0, 12'd1});
      chk("R9 request width one cycle", 32'(dbl_cnt), 32'd0);
      bus_read(OFF_CFG_CTRL[7:0], d); chk("R4 control reads zero", d, 32'h0);

      sweep_reads();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule